// File: doc/BRIEF.md
# Overlapped-Translation Data Cache

This block is a read-only, direct-mapped data cache whose array lookup runs in the same cycle as the address translation. The cache index and byte offset come only from the page-offset part of the virtual address, so the array can be read before the physical address is known. The upper virtual bits go out to an external translation buffer. Its physical frame number comes back in the same cycle and is compared against the frame tag stored in the selected line.

With the default parameters the cache holds 1024 lines of one 32-bit word each (4 KB). Addresses are 32 bits: a 20-bit page number and a 12-bit page offset. A hit answers in the request cycle. A line miss with a translation hit fetches the word from memory by its physical address and fills the line. A translation miss raises a request to the translation handler, waits for it to complete, and then retries the lookup. Only one miss is in flight at a time, and the CPU port stalls until it ends. Any parameter choice whose index would reach past the page offset is refused at elaboration.

Top module: `vipt_cache`

## Requirements
- R1: When a request's line is valid and its stored frame tag equals the frame returned by the translation buffer (which reports a hit), `cpu_ready` is high in the request cycle with the line's word on `cpu_data`, and `mem_req` stays low.
- R2: The line index is `cpu_va[11:2]`. Bits `cpu_va[1:0]` do not affect the lookup or the returned word.
- R3: Lines are tagged by physical frame. Two virtual pages that map to the same frame share lines, so the second page hits without a memory read. Pages that map to different frames at the same index evict each other.
- R4: On a line miss with a translation hit, the request cycle ends without `cpu_ready`. From the next cycle on, `mem_req` is high with `mem_pa = {frame, cpu_va[11:2], 2'b00}`, held stable while `cpu_ready` is low. In the cycle `mem_valid` is high, `cpu_ready` is high and `cpu_data` equals `mem_data`. With a memory latency of N cycles of `mem_req`, ready comes N cycles after the request cycle.
- R5: A fill writes the word, the frame tag and the valid bit, so the next read of the same physical line hits and returns the filled word.
- R6: On a translation miss, `xlat_req` goes high from the next cycle on, with `tlb_vpn` held at the request's page number and `mem_req` low. After the cycle in which `xlat_done` is high, the lookup is retried.
- R7: During a lookup, `tlb_vpn` equals `cpu_va[31:12]`.
- R8: A cycle with `inv_all` high clears every valid bit, and no request is accepted in that cycle when no fill is finishing.
- R9: While reset is asserted and after it is released, `cpu_ready`, `mem_req` and `xlat_req` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear every valid bit |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_va | input | 32 | Virtual byte address of the read |
| cpu_ready | output | 1 | Read complete this cycle |
| cpu_data | output | 32 | Read word |
| tlb_vpn | output | 20 | Page number sent for translation |
| tlb_hit | input | 1 | Translation buffer holds `tlb_vpn` |
| tlb_pfn | input | 20 | Physical frame for `tlb_vpn` |
| xlat_req | output | 1 | Translation miss, handler must load the entry |
| xlat_done | input | 1 | Handler finished |
| mem_req | output | 1 | Line fill read request |
| mem_pa | output | 32 | Physical word address of the fill |
| mem_valid | input | 1 | Fill data valid |
| mem_data | input | 32 | Fill data |

## Verification
The assertions assume a well-behaved environment. The CPU keeps `cpu_req` and `cpu_va` steady until `cpu_ready`. `mem_valid` arrives only while `mem_req` is high, and `xlat_done` only while `xlat_req` is high. The translation buffer answers combinationally for the page number being presented. The bench's read task holds the address for the whole transaction. Its memory and handler models raise their completion strobes only after counting cycles of the matching request, and its translation model is a small table driven from `tlb_vpn` alone.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_XLAT = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int LINES = 1024,
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_mem [LINES];

  // next-state for the valid vector; a clear overrides a fill write
  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
    if (clr_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int LINES  = 1024,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_mem[wr_idx] <= wr_data;
  end

  assign rd_data = word_mem[rd_idx];
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_cache_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int POFF_W = 12,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_go,
  input  logic              tlb_hit,
  input  logic              line_hit,
  input  logic              xlat_done,
  input  logic              mem_valid,
  input  logic [VPN_W-1:0]  cur_vpn,
  input  logic [POFF_W-1:0] cur_off,
  input  logic [PFN_W-1:0]  cur_pfn,
  output ctl_state_e        state,
  output logic [VPN_W-1:0]  held_vpn,
  output logic [PFN_W-1:0]  held_pfn,
  output logic [POFF_W-1:0] held_off
);
  ctl_state_e        state_q, state_d;
  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic [PFN_W-1:0]  pfn_q, pfn_d;
  logic [POFF_W-1:0] off_q, off_d;
  logic              cap_en;
  logic [OFF_W-1:0]  unused_byte;

  assign cap_en      = (state_q == ST_LOOK) && lookup_go;
  assign unused_byte = cur_off[OFF_W-1:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOK: if (lookup_go) begin
                 if (!tlb_hit)      state_d = ST_XLAT;
                 else if (!line_hit) state_d = ST_FILL;
               end
      ST_XLAT: if (xlat_done) state_d = ST_LOOK;
      ST_FILL: if (mem_valid) state_d = ST_LOOK;
      default: state_d = ST_LOOK;
    endcase
  end

  // capture registers with explicit enable; byte bits forced to zero
  always_comb begin
    vpn_d = vpn_q;
    pfn_d = pfn_q;
    off_d = off_q;
    if (cap_en) begin
      vpn_d = cur_vpn;
      pfn_d = cur_pfn;
      off_d = {cur_off[POFF_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOOK;
      vpn_q   <= '0;
      pfn_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      vpn_q   <= vpn_d;
      pfn_q   <= pfn_d;
      off_q   <= off_d;
    end
  end

  assign state    = state_q;
  assign held_vpn = vpn_q;
  assign held_pfn = pfn_q;
  assign held_off = off_q;
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_cache_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int POFF_W     = 12,
  parameter int NUM_LINES  = 1024,
  parameter int LINE_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_all,
  input  logic                     cpu_req,
  input  logic [VA_W-1:0]          cpu_va,
  output logic                     cpu_ready,
  output logic [8*LINE_BYTES-1:0]  cpu_data,
  output logic [VA_W-POFF_W-1:0]   tlb_vpn,
  input  logic                     tlb_hit,
  input  logic [PA_W-POFF_W-1:0]   tlb_pfn,
  output logic                     xlat_req,
  input  logic                     xlat_done,
  output logic                     mem_req,
  output logic [PA_W-1:0]          mem_pa,
  input  logic                     mem_valid,
  input  logic [8*LINE_BYTES-1:0]  mem_data
);
  localparam int VPN_W  = VA_W - POFF_W;
  localparam int PFN_W  = PA_W - POFF_W;
  localparam int DATA_W = 8 * LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int HI_W   = POFF_W - IDX_W - OFF_W;
  localparam int TAG_W  = PFN_W + ((HI_W > 0) ? HI_W : 0);

  // The index must come from page-offset bits only, or the overlap is invalid.
  if (HI_W < 0) begin : g_bad_geometry
    $error("cache index reaches beyond the page offset");
  end

  ctl_state_e        state;
  logic [VPN_W-1:0]  held_vpn;
  logic [PFN_W-1:0]  held_pfn;
  logic [POFF_W-1:0] held_off;
  logic              lookup_go, in_look, line_hit, tlb_line_hit, fill_we;
  logic [IDX_W-1:0]  look_idx, fill_idx;
  logic [TAG_W-1:0]  look_tag, fill_tag, rd_tag;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  assign in_look   = (state == ST_LOOK);
  assign lookup_go = cpu_req && !inv_all;
  assign look_idx  = cpu_va[OFF_W +: IDX_W];
  assign fill_idx  = held_off[OFF_W +: IDX_W];
  assign fill_we   = (state == ST_FILL) && mem_valid;

  // physical tag: frame number, plus any offset bits above the index
  if (HI_W > 0) begin : g_tag_hi
    assign look_tag = {tlb_pfn, cpu_va[POFF_W-1:IDX_W+OFF_W]};
    assign fill_tag = {held_pfn, held_off[POFF_W-1:IDX_W+OFF_W]};
  end else begin : g_tag_frame
    logic [VA_W-IDX_W-OFF_W-1:0] unused_upper;
    assign unused_upper = cpu_va[VA_W-1:IDX_W+OFF_W];
    assign look_tag = tlb_pfn;
    assign fill_tag = held_pfn;
  end

  assign line_hit     = rd_valid && (rd_tag == look_tag);
  assign tlb_line_hit = in_look && lookup_go && tlb_hit && line_hit;

  vipt_tag_store #(.LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (inv_all),
    .rd_idx   (look_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .wr_en    (fill_we),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag)
  );

  vipt_data_store #(.LINES(NUM_LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (look_idx),
    .rd_data (rd_data),
    .wr_en   (fill_we),
    .wr_idx  (fill_idx),
    .wr_data (mem_data)
  );

  vipt_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W), .POFF_W(POFF_W), .OFF_W(OFF_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookup_go (lookup_go),
    .tlb_hit   (tlb_hit),
    .line_hit  (line_hit),
    .xlat_done (xlat_done),
    .mem_valid (mem_valid),
    .cur_vpn   (cpu_va[VA_W-1:POFF_W]),
    .cur_off   (cpu_va[POFF_W-1:0]),
    .cur_pfn   (tlb_pfn),
    .state     (state),
    .held_vpn  (held_vpn),
    .held_pfn  (held_pfn),
    .held_off  (held_off)
  );

  assign tlb_vpn   = in_look ? cpu_va[VA_W-1:POFF_W] : held_vpn;
  assign xlat_req  = (state == ST_XLAT);
  assign mem_req   = (state == ST_FILL);
  assign mem_pa    = {held_pfn, held_off};
  assign cpu_ready = tlb_line_hit || fill_we;
  assign cpu_data  = (state == ST_FILL) ? mem_data : rd_data;
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int POFF_W     = 12,
  parameter int LINE_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inv_all,
  input logic                    cpu_req,
  input logic                    cpu_ready,
  input logic [8*LINE_BYTES-1:0] cpu_data,
  input logic [VA_W-POFF_W-1:0]  tlb_vpn,
  input logic                    tlb_hit,
  input logic                    xlat_req,
  input logic                    xlat_done,
  input logic                    mem_req,
  input logic [PA_W-1:0]         mem_pa,
  input logic                    mem_valid,
  input logic [8*LINE_BYTES-1:0] mem_data
);
  assert_hit_needs_tlb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !mem_req |-> tlb_hit && cpu_req);

  assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_pa));

  assert_fill_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |-> !cpu_ready);

  assert_fill_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |-> cpu_ready && (cpu_data == mem_data));

  assert_single_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xlat_req));

  assert_xlat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req && !xlat_done |=> xlat_req && $stable(tlb_vpn));

  assert_xlat_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |-> !cpu_ready);

  assert_inv_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !mem_req |-> !cpu_ready);

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |-> !mem_req && !xlat_req && !cpu_ready);
endmodule

bind vipt_cache vipt_cache_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .POFF_W(POFF_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
  localparam int MEM_LAT  = 3;
  localparam int XLAT_LAT = 2;

  logic        clk, rst_n, inv_all, cpu_req, cpu_ready;
  logic [31:0] cpu_va, cpu_data, mem_pa, mem_data;
  logic [19:0] tlb_vpn, tlb_pfn;
  logic        tlb_hit, xlat_req, xlat_done, mem_req, mem_valid;

  int n_checks = 0;
  int n_fail   = 0;

  // bench translation table: 16 entries indexed by page number bits [3:0]
  logic        tv [16];
  logic [19:0] tp [16];
  // bench reference line state
  logic        ev [1024];
  logic [19:0] et [1024];
  logic [31:0] ed [1024];

  vipt_cache uut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .cpu_req(cpu_req), .cpu_va(cpu_va),
    .cpu_ready(cpu_ready), .cpu_data(cpu_data), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit),
    .tlb_pfn(tlb_pfn), .xlat_req(xlat_req), .xlat_done(xlat_done), .mem_req(mem_req),
    .mem_pa(mem_pa), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // pages 2k and 2k+1 share one frame
  function automatic logic [19:0] frame_of(input logic [19:0] v);
    return {v[19:1] ^ 19'h2A5C3, 1'b1};
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] pa);
    return (pa * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic tlb_has(input logic [19:0] v);
    return tv[v[3:0]] && (tp[v[3:0]] == v);
  endfunction

  always_comb begin
    tlb_hit = tlb_has(tlb_vpn);
    tlb_pfn = frame_of(tlb_vpn);
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] va);
    logic [19:0] vpn, pfn;
    logic [9:0]  idx;
    logic [31:0] pa, exp_data, data;
    logic        in_tlb, exp_hit, retry_hit, got, saw_m, saw_x, pa_ok, vpn_ok;
    int          cyc, mw, xw;
    vpn       = va[31:12];
    idx       = va[11:2];
    pfn       = frame_of(vpn);
    pa        = {pfn, va[11:2], 2'b00};
    in_tlb    = tlb_has(vpn);
    retry_hit = ev[idx] && (et[idx] == pfn);
    exp_hit   = in_tlb && retry_hit;
    exp_data  = retry_hit ? ed[idx] : word_at(pa);
    got = 0; saw_m = 0; saw_x = 0; pa_ok = 1; cyc = 0; mw = 0; xw = 0; data = '0;
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_va  = va;
    #1;
    vpn_ok = (tlb_vpn == vpn);
    while (!got && cyc < 60) begin
      if (cpu_ready) begin
        got  = 1;
        data = cpu_data;
      end else begin
        if (xlat_req) begin
          saw_x = 1;
          if (tlb_vpn != vpn) vpn_ok = 0;
          xw++;
          if (xw == XLAT_LAT) begin
            xlat_done = 1'b1;
            tv[vpn[3:0]] = 1'b1;
            tp[vpn[3:0]] = vpn;
          end
        end
        if (mem_req) begin
          saw_m = 1;
          if (mem_pa != pa) pa_ok = 0;
          mw++;
          if (mw == MEM_LAT) begin
            mem_valid = 1'b1;
            mem_data  = word_at(mem_pa);
            #1;
            if (cpu_ready) begin
              got  = 1;
              data = cpu_data;
            end
          end
        end
        if (!got) begin
          @(negedge clk);
          mem_valid = 1'b0;
          xlat_done = 1'b0;
          cyc++;
          #1;
        end
      end
    end
    @(negedge clk);
    mem_valid = 1'b0;
    xlat_done = 1'b0;
    cpu_req   = 1'b0;
    check(got == 1, "R4 read completes", {31'd0, got}, 32'd1);
    check(vpn_ok, "R7 page number presented", {12'd0, tlb_vpn}, {12'd0, vpn});
    if (exp_hit) begin
      check(data == exp_data, "R1 hit data", data, exp_data);
      check(cyc == 0 && !saw_m && !saw_x, "R1 hit in request cycle", cyc, 0);
    end else if (in_tlb) begin
      check(data == exp_data, "R5 fill data", data, exp_data);
      check(saw_m && pa_ok, "R4 fill physical address", mem_pa, pa);
      check(cyc == MEM_LAT, "R4 miss latency", cyc, MEM_LAT);
    end else begin
      check(saw_x, "R6 translation request", {31'd0, saw_x}, 32'd1);
      check(saw_m == !retry_hit, "R3 retry uses physical tag", {31'd0, saw_m},
            {31'd0, !retry_hit});
      check(data == exp_data, "R6 data after retry", data, exp_data);
      if (saw_m) check(pa_ok, "R4 fill physical address", mem_pa, pa);
    end
    if (!retry_hit) begin
      ev[idx] = 1'b1;
      et[idx] = pfn;
      ed[idx] = word_at(pa);
    end
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inv_all = 1'b0; cpu_req = 1'b0; cpu_va = '0;
    xlat_done = 1'b0; mem_valid = 1'b0; mem_data = '0;
    for (int i = 0; i < 16; i++) begin tv[i] = 1'b0; tp[i] = '0; end
    for (int i = 0; i < 1024; i++) begin ev[i] = 1'b0; et[i] = '0; ed[i] = '0; end
    repeat (3) @(negedge clk);
    check(!cpu_ready && !mem_req && !xlat_req, "R9 outputs in reset",
          {29'd0, cpu_ready, mem_req, xlat_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_ready && !mem_req && !xlat_req, "R9 idle after reset",
          {29'd0, cpu_ready, mem_req, xlat_req}, 32'd0);

    // R9/R5: every line starts invalid; fill all lines of one page, then reread
    for (int i = 0; i < 1024; i++) do_read({20'h00040, i[9:0], 2'b00});
    for (int i = 0; i < 1024; i++) do_read({20'h00040, i[9:0], 2'b00});

    // R2: byte offset bits do not change the line or word
    for (int i = 0; i < 32; i++) do_read({20'h00040, i[9:0], i[1:0] | 2'b01});

    // R3: an aliasing page on the same frame hits after its translation
    for (int i = 0; i < 64; i++) do_read({20'h00041, i[9:0] + 10'd100, 2'b10});

    // R3/R6: a different frame at the same indices evicts, then back again
    for (int i = 0; i < 64; i++) do_read({20'h00130, i[9:0], 2'b00});
    for (int i = 0; i < 64; i++) do_read({20'h00040, i[9:0], 2'b00});

    // R8: invalidate blocks the request in its cycle and clears every line
    @(negedge clk);
    cpu_req = 1'b1; cpu_va = {20'h00040, 10'd500, 2'b00}; inv_all = 1'b1;
    #1;
    check(!cpu_ready, "R8 request blocked during invalidate", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    inv_all = 1'b0; cpu_req = 1'b0;
    for (int i = 0; i < 1024; i++) ev[i] = 1'b0;
    for (int i = 490; i < 530; i++) do_read({20'h00040, i[9:0], 2'b00});
    for (int i = 490; i < 530; i++) do_read({20'h00041, i[9:0], 2'b00});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule